// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block takes a freshly powered DDR2 or DDR3 SDRAM through its mandatory bring-up sequence and leaves it ready for normal traffic. After a start pulse it walks a fixed list of steps for the selected memory type. Each step either issues a memory command, holds a timed pause, or changes one of two mode flags (DLL reset, OCD default) that a neighbouring block folds into the next mode-register load. Every command appears as a one-cycle strobe with a 3-bit command code and a 3-bit bank value. The sequencer waits for the command interface to accept the command before it moves to the next step.

Pauses are given in microseconds and converted to clock cycles with a run-time prescaler (cycles per microsecond). The block also computes the bit position where the bank address sits in the system address. It derives this position from the column-count field, the row-count field, the bus width and whether address decoding is interleaved, so that extended mode-register loads reach the right register. After the final write access has been accepted, a done flag rises and stays high until reset.

Top module: `dram_init_seq`

## Requirements
- R1: With sequential decoding (`interleave`=0), `bankPos` = `colField` + 9 + `rowField` + 11 + (1 when `wideBus`=0, 2 when `wideBus`=1).
- R2: With interleaved decoding (`interleave`=1), `bankPos` drops the row term: `colField` + 9 + (1 or 2 by `wideBus`).
- R3: For DDR2 (`memIsDdr3`=0 at start), the command codes issued are, in order: NOP, NOP, precharge-all, EMRS bank 2, EMRS bank 3, EMRS bank 1, MRS, precharge-all, refresh, refresh, MRS, EMRS bank 1, EMRS bank 1, normal, write. The codes are NOP=0, precharge-all=1, MRS=2, EMRS=3, refresh=4, ZQ calibration=5, normal=6, write=7.
- R4: For DDR3, the command codes issued are, in order: NOP, NOP, EMRS bank 2, EMRS bank 3, EMRS bank 1, MRS, ZQ calibration, normal, write.
- R5: In the DDR2 sequence, `dllReset` is high from the first MRS through the second refresh, and low at every other command.
- R6: In the DDR2 sequence, `ocdDefault` is high at the first of the two closing EMRS bank 1 commands and low at every other command. It is never high together with `dllReset`.
- R7: The gap between the two NOP strobes is at least N×P cycles, with N = 200 for DDR2 and 500 for DDR3. The gap between the DDR3 MRS and ZQ strobes is at least 50×P cycles. P is `usPrescale`, and a value of 0 counts as 1. Each gap exceeds its minimum by no more than the acknowledge latency plus 8 cycles.
- R8: `cmdValid` is high for exactly one cycle per command. No further strobe occurs until `cmdAck` has been seen for that command. An ack in the strobe cycle itself counts.
- R9: EMRS commands carry the register index (1, 2 or 3) on `cmdBank`. Every other command carries bank 0.
- R10: `initDone` is low until the write command has been acknowledged, then stays high with no further strobes until reset.
- R11: A start pulse while a sequence runs or after it has completed has no effect. The command order follows the memory type latched at the first start.
- R12: Sampled low at a clock edge, `rstN` returns the block to idle. After that edge `cmdValid`, `dllReset`, `ocdDefault` and `initDone` are low, and no command is issued until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start pulse, honoured only while idle |
| memIsDdr3 | input | 1 | Memory type: 0 DDR2, 1 DDR3; latched at start |
| usPrescale | input | 8 | Clock cycles per microsecond (0 behaves as 1) |
| colField | input | 2 | Column-count field |
| rowField | input | 2 | Row-count field |
| interleave | input | 1 | 1 selects interleaved bank decoding |
| wideBus | input | 1 | 1 for a 32-bit data bus, 0 for 16-bit |
| cmdAck | input | 1 | Command accepted by the command interface |
| cmdValid | output | 1 | One-cycle command strobe |
| cmdCode | output | 3 | Command code, valid with the strobe |
| cmdBank | output | 3 | Bank value, valid with the strobe |
| bankPos | output | 5 | Bit position of the bank address |
| dllReset | output | 1 | DLL-reset mode flag |
| ocdDefault | output | 1 | OCD-default mode flag |
| initDone | output | 1 | Initialization complete, sticky until reset |

## Verification
If the step index is corrupted or the wrong memory type is latched, the error shows at the very next strobe as a wrong code or bank against the expected list. A fault in the pause counter shows up in the gap between the two NOP strobes, or between the DDR3 MRS and ZQ strobes, measured against N×P. A flag step that is skipped or taken twice shows at the next MRS or EMRS strobe as a wrong `dllReset` or `ocdDefault` value. A faulty offset path is visible on `bankPos` as soon as the configuration inputs settle, because that output is combinational.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_PREALL  = 3'd1,
    CMD_MRS     = 3'd2,
    CMD_EMRS    = 3'd3,
    CMD_REFRESH = 3'd4,
    CMD_ZQCAL   = 3'd5,
    CMD_NORMAL  = 3'd6,
    CMD_WRITE   = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    K_CMD, K_WAIT, K_DLL_SET, K_DLL_CLR, K_OCD_SET, K_OCD_CLR, K_DONE
  } kind_e;

  // waitSel: 0 DDR2 power-up pause, 1 DDR3 power-up pause, 2 DDR3 DLL pause
  typedef struct packed {
    kind_e      kind;
    cmd_e       code;
    logic [2:0] bank;
    logic [1:0] waitSel;
  } step_t;

  typedef struct packed {
    logic       loadWait;
    logic [1:0] waitSel;
  } dpCtrl_t;

  localparam int STEP_W = 5;

  function automatic step_t mkStep(kind_e k, cmd_e c, logic [2:0] b, logic [1:0] w);
    step_t s;
    s.kind = k; s.code = c; s.bank = b; s.waitSel = w;
    return s;
  endfunction

  function automatic step_t cmdStep(cmd_e c, logic [2:0] b);
    return mkStep(K_CMD, c, b, 2'd0);
  endfunction

  function automatic step_t stepOf(logic isDdr3, logic [STEP_W-1:0] idx);
    step_t s;
    s = mkStep(K_DONE, CMD_NOP, 3'd0, 2'd0);
    if (!isDdr3) begin
      case (idx)
        5'd0:  s = cmdStep(CMD_NOP, 3'd0);
        5'd1:  s = mkStep(K_WAIT, CMD_NOP, 3'd0, 2'd0);
        5'd2:  s = cmdStep(CMD_NOP, 3'd0);
        5'd3:  s = cmdStep(CMD_PREALL, 3'd0);
        5'd4:  s = cmdStep(CMD_EMRS, 3'd2);
        5'd5:  s = cmdStep(CMD_EMRS, 3'd3);
        5'd6:  s = cmdStep(CMD_EMRS, 3'd1);
        5'd7:  s = mkStep(K_DLL_SET, CMD_NOP, 3'd0, 2'd0);
        5'd8:  s = cmdStep(CMD_MRS, 3'd0);
        5'd9:  s = cmdStep(CMD_PREALL, 3'd0);
        5'd10: s = cmdStep(CMD_REFRESH, 3'd0);
        5'd11: s = cmdStep(CMD_REFRESH, 3'd0);
        5'd12: s = mkStep(K_DLL_CLR, CMD_NOP, 3'd0, 2'd0);
        5'd13: s = cmdStep(CMD_MRS, 3'd0);
        5'd14: s = mkStep(K_OCD_SET, CMD_NOP, 3'd0, 2'd0);
        5'd15: s = cmdStep(CMD_EMRS, 3'd1);
        5'd16: s = mkStep(K_OCD_CLR, CMD_NOP, 3'd0, 2'd0);
        5'd17: s = cmdStep(CMD_EMRS, 3'd1);
        5'd18: s = cmdStep(CMD_NORMAL, 3'd0);
        5'd19: s = cmdStep(CMD_WRITE, 3'd0);
        default: ;
      endcase
    end else begin
      case (idx)
        5'd0:  s = cmdStep(CMD_NOP, 3'd0);
        5'd1:  s = mkStep(K_WAIT, CMD_NOP, 3'd0, 2'd1);
        5'd2:  s = cmdStep(CMD_NOP, 3'd0);
        5'd3:  s = cmdStep(CMD_EMRS, 3'd2);
        5'd4:  s = cmdStep(CMD_EMRS, 3'd3);
        5'd5:  s = cmdStep(CMD_EMRS, 3'd1);
        5'd6:  s = cmdStep(CMD_MRS, 3'd0);
        5'd7:  s = mkStep(K_WAIT, CMD_NOP, 3'd0, 2'd2);
        5'd8:  s = cmdStep(CMD_ZQCAL, 3'd0);
        5'd9:  s = cmdStep(CMD_NORMAL, 3'd0);
        5'd10: s = cmdStep(CMD_WRITE, 3'd0);
        default: ;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/dram_init_dp.sv
module dram_init_dp
  import dram_init_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int US_W        = 10,
  parameter int FIELD_W     = 2,
  parameter int POS_W       = 5,
  parameter int DDR2_PWR_US = 200,
  parameter int DDR3_PWR_US = 500,
  parameter int DDR3_DLL_US = 50
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            ctrl,
  input  logic [PRE_W-1:0]   usPrescale,
  input  logic [FIELD_W-1:0] colField,
  input  logic [FIELD_W-1:0] rowField,
  input  logic               interleave,
  input  logic               wideBus,
  output logic               waitDone,
  output logic [POS_W-1:0]   bankPos
);

  localparam logic [POS_W-1:0] COL_BASE = POS_W'(9);
  localparam logic [POS_W-1:0] ROW_BASE = POS_W'(11);

  logic [US_W-1:0]  usLeft;
  logic [PRE_W-1:0] subCnt;
  logic [US_W-1:0]  loadAmt;
  logic             usTick;
  logic [POS_W-1:0] rowTerm;
  logic [POS_W-1:0] busTerm;

  // a microsecond has elapsed once subCnt reaches prescale-1 (0 acts as 1)
  assign usTick = ({1'b0, subCnt} + 1'b1) >= {1'b0, usPrescale};

  always_comb begin
    case (ctrl.waitSel)
      2'd0:    loadAmt = US_W'(DDR2_PWR_US);
      2'd1:    loadAmt = US_W'(DDR3_PWR_US);
      2'd2:    loadAmt = US_W'(DDR3_DLL_US);
      default: loadAmt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usLeft <= '0;
      subCnt <= '0;
    end else if (ctrl.loadWait) begin
      usLeft <= loadAmt;
      subCnt <= '0;
    end else if (usLeft != '0) begin
      if (usTick) begin
        subCnt <= '0;
        usLeft <= usLeft - 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  assign waitDone = (usLeft == '0);

  assign rowTerm = interleave ? '0 : (POS_W'(rowField) + ROW_BASE);
  assign busTerm = wideBus ? POS_W'(2) : POS_W'(1);
  assign bankPos = POS_W'(colField) + COL_BASE + rowTerm + busTerm;

endmodule

// File: rtl/dram_init_ctrl.sv
module dram_init_ctrl
  import dram_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       memIsDdr3,
  input  logic       cmdAck,
  input  logic       waitDone,
  output dpCtrl_t    dpCtrl,
  output logic       cmdValid,
  output logic [2:0] cmdCode,
  output logic [2:0] cmdBank,
  output logic       dllReset,
  output logic       ocdDefault,
  output logic       initDone
);

  typedef enum logic [2:0] {S_IDLE, S_STEP, S_ISSUE, S_ACK, S_DELAY, S_DONE} state_e;

  state_e            state;
  logic [STEP_W-1:0] stepIdx;
  logic              isDdr3Q;
  step_t             curStep;

  assign curStep = stepOf(isDdr3Q, stepIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      stepIdx    <= '0;
      isDdr3Q    <= 1'b0;
      dllReset   <= 1'b0;
      ocdDefault <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          isDdr3Q <= memIsDdr3;
          stepIdx <= '0;
          state   <= S_STEP;
        end
        S_STEP: begin
          case (curStep.kind)
            K_CMD:     state <= S_ISSUE;
            K_WAIT:    state <= S_DELAY;
            K_DLL_SET: begin dllReset   <= 1'b1; stepIdx <= stepIdx + 1'b1; end
            K_DLL_CLR: begin dllReset   <= 1'b0; stepIdx <= stepIdx + 1'b1; end
            K_OCD_SET: begin ocdDefault <= 1'b1; stepIdx <= stepIdx + 1'b1; end
            K_OCD_CLR: begin ocdDefault <= 1'b0; stepIdx <= stepIdx + 1'b1; end
            default:   state <= S_DONE;
          endcase
        end
        S_ISSUE: begin
          if (cmdAck) begin
            stepIdx <= stepIdx + 1'b1;
            state   <= S_STEP;
          end else begin
            state   <= S_ACK;
          end
        end
        S_ACK: if (cmdAck) begin
          stepIdx <= stepIdx + 1'b1;
          state   <= S_STEP;
        end
        S_DELAY: if (waitDone) begin
          stepIdx <= stepIdx + 1'b1;
          state   <= S_STEP;
        end
        default: ;
      endcase
    end
  end

  assign dpCtrl.loadWait = (state == S_STEP) && (curStep.kind == K_WAIT);
  assign dpCtrl.waitSel  = curStep.waitSel;
  assign cmdValid        = (state == S_ISSUE);
  assign cmdCode         = curStep.code;
  assign cmdBank         = curStep.bank;
  assign initDone        = (state == S_DONE);

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int US_W        = 10,
  parameter int FIELD_W     = 2,
  parameter int POS_W       = 5,
  parameter int DDR2_PWR_US = 200,
  parameter int DDR3_PWR_US = 500,
  parameter int DDR3_DLL_US = 50
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               memIsDdr3,
  input  logic [PRE_W-1:0]   usPrescale,
  input  logic [FIELD_W-1:0] colField,
  input  logic [FIELD_W-1:0] rowField,
  input  logic               interleave,
  input  logic               wideBus,
  input  logic               cmdAck,
  output logic               cmdValid,
  output logic [2:0]         cmdCode,
  output logic [2:0]         cmdBank,
  output logic [POS_W-1:0]   bankPos,
  output logic               dllReset,
  output logic               ocdDefault,
  output logic               initDone
);

  dpCtrl_t dpCtrl;
  logic    waitDone;

  dram_init_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .memIsDdr3  (memIsDdr3),
    .cmdAck     (cmdAck),
    .waitDone   (waitDone),
    .dpCtrl     (dpCtrl),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .cmdBank    (cmdBank),
    .dllReset   (dllReset),
    .ocdDefault (ocdDefault),
    .initDone   (initDone)
  );

  dram_init_dp #(
    .PRE_W       (PRE_W),
    .US_W        (US_W),
    .FIELD_W     (FIELD_W),
    .POS_W       (POS_W),
    .DDR2_PWR_US (DDR2_PWR_US),
    .DDR3_PWR_US (DDR3_PWR_US),
    .DDR3_DLL_US (DDR3_DLL_US)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (dpCtrl),
    .usPrescale (usPrescale),
    .colField   (colField),
    .rowField   (rowField),
    .interleave (interleave),
    .wideBus    (wideBus),
    .waitDone   (waitDone),
    .bankPos    (bankPos)
  );

endmodule

// File: rtl/dram_init_chk.sv
module dram_init_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [2:0] cmdCode,
  input logic [2:0] cmdBank,
  input logic       dllReset,
  input logic       ocdDefault,
  input logic       initDone
);

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  p_ext_bank_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'd3) |-> (cmdBank != 3'd0 && cmdBank <= 3'd3));

  p_plain_bank_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode != 3'd3) |-> (cmdBank == 3'd0));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> !cmdValid);

  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    ocdDefault |-> !dllReset);

  p_reset_clears_r12: assert property (@(posedge clk)
    !rstN |=> (!cmdValid && !dllReset && !ocdDefault && !initDone));

endmodule

bind dram_init_seq dram_init_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .cmdCode    (cmdCode),
  .cmdBank    (cmdBank),
  .dllReset   (dllReset),
  .ocdDefault (ocdDefault),
  .initDone   (initDone)
);

// File: tb/dram_init_seq_tb.sv
module dram_init_seq_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       memIsDdr3 = 1'b0;
  logic [7:0] usPrescale = 8'd1;
  logic [1:0] colField = 2'd0;
  logic [1:0] rowField = 2'd0;
  logic       interleave = 1'b0;
  logic       wideBus = 1'b0;
  logic       cmdAck = 1'b0;
  logic       cmdValid;
  logic [2:0] cmdCode;
  logic [2:0] cmdBank;
  logic [4:0] bankPos;
  logic       dllReset;
  logic       ocdDefault;
  logic       initDone;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ackDelay = 0;
  int recCount = 0;
  int recCode [0:31];
  int recBank [0:31];
  int recDll  [0:31];
  int recOcd  [0:31];
  int recDone [0:31];
  int recCyc  [0:31];

  always #4 clk = ~clk;

  dram_init_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .memIsDdr3(memIsDdr3),
    .usPrescale(usPrescale), .colField(colField), .rowField(rowField),
    .interleave(interleave), .wideBus(wideBus), .cmdAck(cmdAck),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdBank(cmdBank),
    .bankPos(bankPos), .dllReset(dllReset), .ocdDefault(ocdDefault),
    .initDone(initDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int expLen(bit d3);
    return d3 ? 9 : 15;
  endfunction

  function automatic int expCode(bit d3, int i);
    int d2c [0:14] = '{0, 0, 1, 3, 3, 3, 2, 1, 4, 4, 2, 3, 3, 6, 7};
    int d3c [0:8]  = '{0, 0, 3, 3, 3, 2, 5, 6, 7};
    return d3 ? d3c[i] : d2c[i];
  endfunction

  function automatic int expBank(bit d3, int i);
    int d2b [0:14] = '{0, 0, 0, 2, 3, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0};
    int d3b [0:8]  = '{0, 0, 2, 3, 1, 0, 0, 0, 0};
    return d3 ? d3b[i] : d2b[i];
  endfunction

  function automatic int expDll(bit d3, int i);
    return (!d3 && i >= 6 && i <= 9) ? 1 : 0;
  endfunction

  function automatic int expOcd(bit d3, int i);
    return (!d3 && i == 11) ? 1 : 0;
  endfunction

  // cycle counter
  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // command recorder and acknowledge responder
  initial forever begin
    @(negedge clk);
    if (rstN && cmdValid) begin
      if (recCount < 32) begin
        recCode[recCount] = cmdCode;
        recBank[recCount] = cmdBank;
        recDll[recCount]  = dllReset;
        recOcd[recCount]  = ocdDefault;
        recDone[recCount] = initDone;
        recCyc[recCount]  = cyc;
      end
      recCount++;
      for (int k = 0; k < ackDelay; k++) begin
        @(negedge clk);
        chk(!cmdValid, "R8 no strobe before ack", cmdValid, 0);
      end
      cmdAck = 1'b1;
      @(negedge clk);
      cmdAck = 1'b0;
      chk(!cmdValid, "R8 strobe one cycle", cmdValid, 0);
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    recCount = 0;
  endtask

  task automatic pulseStart(input bit d3);
    @(negedge clk);
    memIsDdr3 = d3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runSeq(input bit d3, input int pre, input int ad, input bit poke);
    int n;
    int p;
    int gap;
    int seen;
    doReset();
    usPrescale = 8'(pre);
    ackDelay = ad;
    pulseStart(d3);
    if (poke) begin
      while (recCount < 3) @(negedge clk);
      pulseStart(!d3);   // R11: must be ignored mid-run
      memIsDdr3 = d3;
    end
    for (int t = 0; t < 20000 && !initDone; t++) @(negedge clk);
    chk(initDone, "R10 done reached", initDone, 1);
    n = expLen(d3);
    chk(recCount == n, d3 ? "R4 command count" : "R3 command count", recCount, n);
    for (int i = 0; i < n && i < recCount; i++) begin
      chk(recCode[i] == expCode(d3, i), d3 ? "R4 code" : "R3 code", recCode[i], expCode(d3, i));
      chk(recBank[i] == expBank(d3, i), "R9 bank", recBank[i], expBank(d3, i));
      chk(recDll[i] == expDll(d3, i), "R5 dllReset", recDll[i], expDll(d3, i));
      chk(recOcd[i] == expOcd(d3, i), "R6 ocdDefault", recOcd[i], expOcd(d3, i));
      chk(recDone[i] == 0, "R10 done early", recDone[i], 0);
    end
    p = (pre == 0) ? 1 : pre;
    if (recCount >= 2) begin
      gap = recCyc[1] - recCyc[0];
      chk(gap >= (d3 ? 500 : 200) * p, "R7 power-up min", gap, (d3 ? 500 : 200) * p);
      chk(gap <= (d3 ? 500 : 200) * p + ad + 8, "R7 power-up max", gap, (d3 ? 500 : 200) * p + ad + 8);
    end
    if (d3 && recCount >= 7) begin
      gap = recCyc[6] - recCyc[5];
      chk(gap >= 50 * p, "R7 DLL pause min", gap, 50 * p);
      chk(gap <= 50 * p + ad + 8, "R7 DLL pause max", gap, 50 * p + ad + 8);
    end
    seen = recCount;
    repeat (20) @(negedge clk);
    chk(initDone, "R10 done sticky", initDone, 1);
    pulseStart(!d3);
    repeat (30) @(negedge clk);
    chk(recCount == seen, "R11 start after done ignored", recCount, seen);
    chk(initDone, "R10 done sticky after start", initDone, 1);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int exp;
    repeat (3) @(negedge clk);
    chk(!cmdValid && !dllReset && !ocdDefault && !initDone, "R12 reset state",
        {cmdValid, dllReset, ocdDefault, initDone}, 0);
    rstN = 1'b1;

    // R1 / R2 sweep of the offset path
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        for (int il = 0; il < 2; il++)
          for (int w = 0; w < 2; w++) begin
            colField = 2'(c); rowField = 2'(r);
            interleave = 1'(il); wideBus = 1'(w);
            #1;
            exp = c + 9 + (il != 0 ? 0 : r + 11) + (w != 0 ? 2 : 1);
            chk(bankPos == 5'(exp), il != 0 ? "R2 interleaved offset" : "R1 sequential offset",
                bankPos, exp);
          end

    runSeq(1'b0, 1, 0, 1'b0);
    runSeq(1'b0, 4, 2, 1'b1);
    runSeq(1'b1, 3, 1, 1'b0);
    runSeq(1'b1, 0, 0, 1'b1);

    // R12: reset in the middle of the DLL phase
    doReset();
    usPrescale = 8'd1;
    ackDelay = 0;
    pulseStart(1'b0);
    while (recCount < 8) @(negedge clk);
    chk(dllReset, "R12 precondition dllReset", dllReset, 1);
    rstN = 1'b0;
    @(negedge clk);
    chk(!cmdValid && !dllReset && !ocdDefault && !initDone, "R12 mid-run reset",
        {cmdValid, dllReset, ocdDefault, initDone}, 0);
    rstN = 1'b1;
    recCount = 0;
    repeat (40) @(negedge clk);
    chk(recCount == 0, "R12 idle after reset", recCount, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule